// File: doc/BRIEF.md
# Pipeline Hazard and Stall Controller

This block decides, every cycle, whether the instruction in the decode stage of an in-order five-stage pipeline may move on. It also chooses the source of each execute-stage operand. The pipeline has two execute paths. Integer operations, loads and stores spend one cycle in EX. Floating-point additions pass through a pipelined adder with `FP_STAGES` execute steps (four by default). Both paths then share a single memory stage and a single write-back stage.

The block receives the decoded fields of the instruction in decode: a valid bit, a class code, two source register indices, a destination index and a flag that marks store data as a floating-point register. It keeps a small model of the instructions in flight. From that model and the decode fields it derives `stall` combinationally. While `stall` is high, the surrounding datapath holds the PC and the decode register and sends a bubble into execute.

The forwarding selects are decided at issue and registered. In any cycle they describe the operands of the instruction that is currently in its first execute step.

Top module: `hazard_ctrl`

## Requirements
- R1: A synchronous active-high reset empties the in-flight model. After reset, with no valid instruction in decode, `stall` is 0 and both selects are 00. An instruction that entered execute just before a reset creates no dependency for an instruction after it.
- R2: The class code on `id_class` is 0 integer ALU, 1 load, 2 store, 3 FP add. An integer ALU result is forwarded to a store that immediately follows and reads that register as data. The store does not stall, and its data select `fwd_b` is 01.
- R3: An instruction whose operand is the destination of a load directly ahead of it stalls exactly one cycle. The operand may be an ALU source, a base or store data. After the stall its select is 10.
- R4: An FP add that reads the result of the FP add directly ahead of it stalls two cycles. It then takes the value from the adder's last step with select 11.
- R5: A store whose floating-point data register (`id_store_fp`=1) is written by the FP add directly ahead of it stalls three cycles. Two of these cycles wait for the result and one avoids a shared memory stage. The store then issues with data select 01.
- R6: An ALU, load or store instruction in decode stalls one cycle when an FP add sits in the adder step before last. Otherwise both would reach the memory stage together. Three independent integer instructions after an FP add therefore see 0, 0 and 1 stall cycles.
- R7: Integer and floating-point register numbers never match each other. An integer reader of index n is not delayed by an FP add writing index n.
- R8: Integer register 0 never creates a dependency, whether it is written by an ALU operation or by a load.
- R9: The selects use 00 register file, 01 execute/memory result, 10 memory/write-back result and 11 last adder step. When several producers match, the youngest one wins. A producer two instructions ahead gives 10. A producer three ahead gives 00, because the register file write is seen by the read in the same cycle.
- R10: The selects are registered at issue and apply to the instruction in its first execute step. After a stall cycle, or a cycle with no valid instruction, both selects are 00.
- R11: `stall` is 0 whenever `id_valid` is 0. At most one instruction enters the memory stage per cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| id_valid | input | 1 | Decode stage holds an instruction |
| id_class | input | 2 | Instruction class: 0 ALU, 1 load, 2 store, 3 FP add |
| id_src_a | input | 5 | First source (ALU operand, base, or FP operand) |
| id_src_b | input | 5 | Second source (ALU operand, store data, or FP operand) |
| id_dst | input | 5 | Destination register index |
| id_store_fp | input | 1 | Store data register is a floating-point register |
| stall | output | 1 | Hold PC and decode register, insert a bubble |
| fwd_a | output | 2 | Select for the first operand in execute |
| fwd_b | output | 2 | Select for the second operand or store data in execute |

## Verification
The bench counts exact stall cycles for the add-then-store pair, load-use pairs and the FP add followed by a dependent store. A design that treated store data as needed in decode would stall the first pair. One that did not model the shared memory stage would return two stall cycles instead of three for the FP store. It also covers the structural case with independent integer instructions, where a missing check would let two results collide in memory. It checks youngest-producer priority and the three-ahead case, where forwarding stale data would show 01 or 10 instead of 00. Register 0 is covered, and so is an FP destination with the same index as an integer source, where a design that merged the namespaces would stall without cause. A reset during flight checks that no stale dependency survives.

// File: rtl/hz_pkg.sv
package hz_pkg;

    localparam int unsigned HZ_REG_W = 5;

    typedef enum logic [1:0] {
        CL_ALU   = 2'd0,
        CL_LOAD  = 2'd1,
        CL_STORE = 2'd2,
        CL_FADD  = 2'd3
    } op_class_e;

    typedef enum logic [1:0] {
        FW_RF    = 2'd0,
        FW_EXMEM = 2'd1,
        FW_MEMWB = 2'd2,
        FW_FPEND = 2'd3
    } fwd_sel_e;

    // One in-flight instruction as seen by the hazard logic
    typedef struct packed {
        logic                valid;
        logic                wr;
        logic                fp;
        logic                load;
        logic [HZ_REG_W-1:0] dst;
    } slot_t;

    // One source operand of the instruction in decode
    typedef struct packed {
        logic                used;
        logic                fp;
        logic [HZ_REG_W-1:0] idx;
    } operand_t;

    function automatic slot_t slot_of(logic v, op_class_e c, logic [HZ_REG_W-1:0] d);
        slot_t s;
        s = '0;
        if (v) begin
            s.valid = 1'b1;
            s.wr    = (c != CL_STORE);
            s.fp    = (c == CL_FADD);
            s.load  = (c == CL_LOAD);
            s.dst   = d;
        end
        return s;
    endfunction

    function automatic operand_t src_a_of(logic v, op_class_e c, logic [HZ_REG_W-1:0] i);
        operand_t o;
        o.used = v;
        o.fp   = (c == CL_FADD);
        o.idx  = i;
        return o;
    endfunction

    function automatic operand_t src_b_of(logic v, op_class_e c, logic sfp,
                                          logic [HZ_REG_W-1:0] i);
        operand_t o;
        o.used = v && (c != CL_LOAD);
        o.fp   = (c == CL_FADD) || ((c == CL_STORE) && sfp);
        o.idx  = i;
        return o;
    endfunction

    function automatic logic slot_hits(slot_t s, operand_t o);
        return s.valid && s.wr && o.used && (s.fp == o.fp) &&
               (s.dst == o.idx) && (o.fp || (o.idx != '0));
    endfunction

endpackage

// File: rtl/hz_inflight.sv
module hz_inflight
    import hz_pkg::*;
#(
    parameter int FP_STAGES = 4
) (
    input  logic                        clk,
    input  logic                        rst,
    input  slot_t                       issue_int,
    input  slot_t                       issue_fp,
    output slot_t                       ex_slot,
    output slot_t [FP_STAGES-1:0]       fp_slots,
    output slot_t                       mem_slot
);
    localparam int LAST = FP_STAGES - 1;

    slot_t ex_q;
    slot_t mem_q;
    slot_t [FP_STAGES-1:0] fp_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            ex_q    <= '0;
            fp_q[0] <= '0;
        end else begin
            ex_q    <= issue_int;
            fp_q[0] <= issue_fp;
        end
    end

    for (genvar k = 1; k < FP_STAGES; k++) begin : g_fp_step
        always_ff @(posedge clk) begin
            if (rst) fp_q[k] <= '0;
            else     fp_q[k] <= fp_q[k-1];
        end
    end

    // The adder's last step has priority; issue logic keeps the EX slot empty then
    always_ff @(posedge clk) begin
        if (rst)                  mem_q <= '0;
        else if (fp_q[LAST].valid) mem_q <= fp_q[LAST];
        else                      mem_q <= ex_q;
    end

    assign ex_slot  = ex_q;
    assign fp_slots = fp_q;
    assign mem_slot = mem_q;

endmodule

// File: rtl/hz_operand_resolve.sv
module hz_operand_resolve
    import hz_pkg::*;
#(
    parameter int FP_STAGES = 4
) (
    input  operand_t                    opnd,
    input  slot_t                       ex_slot,
    input  slot_t [FP_STAGES-1:0]       fp_slots,
    input  slot_t                       mem_slot,
    output logic                        need_wait,
    output fwd_sel_e                    sel
);
    localparam int FWD_STEP  = FP_STAGES - 2;
    localparam int LAST_STEP = FP_STAGES - 1;

    logic hit;

    // Youngest producer first: EX / first adder step, older adder steps, then MEM
    always_comb begin
        hit       = 1'b0;
        need_wait = 1'b0;
        sel       = FW_RF;
        if (slot_hits(ex_slot, opnd)) begin
            hit = 1'b1;
            if (ex_slot.load) need_wait = 1'b1;
            else              sel       = FW_EXMEM;
        end
        for (int k = 0; k < FP_STAGES; k++) begin
            if (!hit && slot_hits(fp_slots[k], opnd)) begin
                hit = 1'b1;
                if (k == FWD_STEP)       sel       = FW_FPEND;
                else if (k == LAST_STEP) sel       = FW_EXMEM;
                else                     need_wait = 1'b1;
            end
        end
        if (!hit && slot_hits(mem_slot, opnd)) begin
            hit = 1'b1;
            sel = FW_MEMWB;
        end
    end

endmodule

// File: rtl/hz_mem_guard.sv
module hz_mem_guard
    import hz_pkg::*;
#(
    parameter int FP_STAGES = 4
) (
    input  logic                        id_valid,
    input  op_class_e                   id_class,
    input  slot_t [FP_STAGES-1:0]       fp_slots,
    output logic                        mem_clash
);
    // An integer-path instruction issued now reaches MEM two edges later,
    // the same edge as an FP add now in the step before last.
    localparam int CLASH_STEP = FP_STAGES - 2;

    always_comb begin
        mem_clash = id_valid && (id_class != CL_FADD) && fp_slots[CLASH_STEP].valid;
    end

endmodule

// File: rtl/hazard_ctrl.sv
module hazard_ctrl
    import hz_pkg::*;
#(
    parameter int FP_STAGES = 4
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                id_valid,
    input  logic [1:0]          id_class,
    input  logic [HZ_REG_W-1:0] id_src_a,
    input  logic [HZ_REG_W-1:0] id_src_b,
    input  logic [HZ_REG_W-1:0] id_dst,
    input  logic                id_store_fp,
    output logic                stall,
    output logic [1:0]          fwd_a,
    output logic [1:0]          fwd_b
);
    localparam int NUM_OPND = 2;

    op_class_e cls;
    operand_t  opnd [NUM_OPND];
    logic      wait_raw [NUM_OPND];
    fwd_sel_e  sel [NUM_OPND];
    logic      mem_clash;
    logic      go;

    slot_t                 ex_slot;
    slot_t                 mem_slot;
    slot_t [FP_STAGES-1:0] fp_slots;
    slot_t                 issue_int;
    slot_t                 issue_fp;

    logic ex_busy;
    logic fp_last_busy;
    logic fp_near_busy;

    logic [1:0] fwd_a_q;
    logic [1:0] fwd_b_q;

    assign cls     = op_class_e'(id_class);
    assign opnd[0] = src_a_of(id_valid, cls, id_src_a);
    assign opnd[1] = src_b_of(id_valid, cls, id_store_fp, id_src_b);

    for (genvar g = 0; g < NUM_OPND; g++) begin : g_opnd
        hz_operand_resolve #(.FP_STAGES(FP_STAGES)) u_res (
            .opnd      (opnd[g]),
            .ex_slot   (ex_slot),
            .fp_slots  (fp_slots),
            .mem_slot  (mem_slot),
            .need_wait (wait_raw[g]),
            .sel       (sel[g])
        );
    end

    hz_mem_guard #(.FP_STAGES(FP_STAGES)) u_guard (
        .id_valid  (id_valid),
        .id_class  (cls),
        .fp_slots  (fp_slots),
        .mem_clash (mem_clash)
    );

    assign stall = id_valid && (wait_raw[0] || wait_raw[1] || mem_clash);
    assign go    = id_valid && !stall;

    assign issue_int = slot_of(go && (cls != CL_FADD), cls, id_dst);
    assign issue_fp  = slot_of(go && (cls == CL_FADD), cls, id_dst);

    hz_inflight #(.FP_STAGES(FP_STAGES)) u_track (
        .clk       (clk),
        .rst       (rst),
        .issue_int (issue_int),
        .issue_fp  (issue_fp),
        .ex_slot   (ex_slot),
        .fp_slots  (fp_slots),
        .mem_slot  (mem_slot)
    );

    // Selects follow the instruction into its first execute step; bubbles get 00
    always_ff @(posedge clk) begin
        if (rst || !go) begin
            fwd_a_q <= FW_RF;
            fwd_b_q <= FW_RF;
        end else begin
            fwd_a_q <= sel[0];
            fwd_b_q <= sel[1];
        end
    end

    assign fwd_a = fwd_a_q;
    assign fwd_b = fwd_b_q;

    assign ex_busy      = ex_slot.valid;
    assign fp_last_busy = fp_slots[FP_STAGES-1].valid;
    assign fp_near_busy = fp_slots[FP_STAGES-2].valid;

endmodule

// File: rtl/hz_checker.sv
module hz_checker (
    input logic       clk,
    input logic       rst,
    input logic       id_valid,
    input logic [1:0] id_class,
    input logic       stall,
    input logic [1:0] fwd_a,
    input logic [1:0] fwd_b,
    input logic       ex_busy,
    input logic       fp_last_busy,
    input logic       fp_near_busy
);
    // R11
    one_mem_entry_chk: assert property (@(posedge clk) disable iff (rst)
        !(ex_busy && fp_last_busy));

    // R11
    idle_no_stall_chk: assert property (@(posedge clk) disable iff (rst)
        !id_valid |-> !stall);

    // R10
    bubble_sel_chk: assert property (@(posedge clk) disable iff (rst)
        stall |=> (fwd_a == 2'd0 && fwd_b == 2'd0));

    // R4
    fp_end_src_chk: assert property (@(posedge clk) disable iff (rst)
        (fwd_a == 2'd3 || fwd_b == 2'd3) |-> fp_last_busy);

    // R6
    mem_share_chk: assert property (@(posedge clk) disable iff (rst)
        (id_valid && id_class != 2'd3 && fp_near_busy) |-> stall);

endmodule

bind hazard_ctrl hz_checker u_hz_checker (
    .clk          (clk),
    .rst          (rst),
    .id_valid     (id_valid),
    .id_class     (id_class),
    .stall        (stall),
    .fwd_a        (fwd_a),
    .fwd_b        (fwd_b),
    .ex_busy      (ex_busy),
    .fp_last_busy (fp_last_busy),
    .fp_near_busy (fp_near_busy)
);

// File: tb/tb_hazard_ctrl.sv
module tb_hazard_ctrl;

    localparam int ALU = 0, LD = 1, ST = 2, FADD = 3;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       id_valid = 1'b0;
    logic [1:0] id_class = '0;
    logic [4:0] id_src_a = '0;
    logic [4:0] id_src_b = '0;
    logic [4:0] id_dst = '0;
    logic       id_store_fp = 1'b0;
    logic       stall;
    logic [1:0] fwd_a;
    logic [1:0] fwd_b;

    int total = 0;
    int fails = 0;

    always #4 clk = ~clk;

    hazard_ctrl dut (
        .clk(clk), .rst(rst), .id_valid(id_valid), .id_class(id_class),
        .id_src_a(id_src_a), .id_src_b(id_src_b), .id_dst(id_dst),
        .id_store_fp(id_store_fp), .stall(stall), .fwd_a(fwd_a), .fwd_b(fwd_b)
    );

    task automatic chk(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic idle(input int n);
        id_valid = 1'b0;
        repeat (n) @(negedge clk);
    endtask

    // Called at a falling edge; returns at the falling edge after issue
    task automatic issue(input int c, input int a, input int b, input int d, input bit sfp,
                         output int stalls, output int fa, output int fb);
        id_valid    = 1'b1;
        id_class    = 2'(c);
        id_src_a    = 5'(a);
        id_src_b    = 5'(b);
        id_dst      = 5'(d);
        id_store_fp = sfp;
        stalls = 0;
        #1;
        while (stall) begin
            stalls++;
            @(negedge clk);
            #1;
        end
        @(posedge clk);
        @(negedge clk);
        fa = fwd_a;
        fb = fwd_b;
    endtask

    task automatic t_reset();
        int s, fa, fb;
        chk("R1 stall after reset", stall, 0);
        chk("R1 fwd_a after reset", fwd_a, 0);
        chk("R1 fwd_b after reset", fwd_b, 0);
        issue(LD, 2, 0, 1, 0, s, fa, fb);
        id_valid = 1'b0;
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        issue(ALU, 1, 3, 4, 0, s, fa, fb);
        chk("R1 no stall after reset in flight", s, 0);
        chk("R1 fwd_a after reset in flight", fa, 0);
        idle(8);
    endtask

    task automatic t_alu_store();
        int s, fa, fb;
        issue(ALU, 1, 2, 3, 0, s, fa, fb);
        issue(ST, 8, 3, 0, 0, s, fa, fb);
        chk("R2 store stalls", s, 0);
        chk("R2 store data select", fb, 1);
        chk("R2 store base select", fa, 0);
        idle(1);
        chk("R10 select after idle", fwd_b, 0);
        idle(8);
    endtask

    task automatic t_load_use();
        int s, fa, fb;
        issue(LD, 2, 0, 1, 0, s, fa, fb);
        issue(ALU, 1, 2, 4, 0, s, fa, fb);
        chk("R3 load-use stalls", s, 1);
        chk("R3 load-use select", fa, 2);
        issue(ALU, 4, 1, 5, 0, s, fa, fb);
        chk("R9 younger ALU select", fa, 1);
        chk("R9 load in write-back select", fb, 0);
        idle(8);
        issue(LD, 2, 0, 7, 0, s, fa, fb);
        issue(ST, 8, 7, 0, 0, s, fa, fb);
        chk("R3 load-store stalls", s, 1);
        chk("R3 load-store data select", fb, 2);
        idle(8);
    endtask

    task automatic t_fp_chain();
        int s, fa, fb;
        issue(FADD, 4, 5, 2, 0, s, fa, fb);
        issue(FADD, 2, 7, 6, 0, s, fa, fb);
        chk("R4 fp chain stalls", s, 2);
        chk("R4 fp chain select", fa, 3);
        idle(10);
    endtask

    task automatic t_fp_store();
        int s, fa, fb;
        issue(FADD, 4, 5, 2, 0, s, fa, fb);
        issue(ST, 8, 2, 0, 1, s, fa, fb);
        chk("R5 fp store stalls", s, 3);
        chk("R5 fp store data select", fb, 1);
        chk("R5 fp store base select", fa, 0);
        idle(10);
    endtask

    task automatic t_mem_share();
        int s, fa, fb;
        issue(FADD, 1, 2, 1, 0, s, fa, fb);
        issue(ALU, 10, 11, 12, 0, s, fa, fb);
        chk("R6 first int stalls", s, 0);
        issue(ALU, 13, 14, 15, 0, s, fa, fb);
        chk("R6 second int stalls", s, 0);
        issue(ALU, 16, 17, 18, 0, s, fa, fb);
        chk("R6 third int stalls", s, 1);
        idle(10);
    endtask

    task automatic t_namespace();
        int s, fa, fb;
        issue(FADD, 1, 1, 3, 0, s, fa, fb);
        issue(ALU, 3, 3, 7, 0, s, fa, fb);
        chk("R7 int reader stalls", s, 0);
        chk("R7 int reader fwd_a", fa, 0);
        chk("R7 int reader fwd_b", fb, 0);
        idle(10);
    endtask

    task automatic t_reg_zero();
        int s, fa, fb;
        issue(ALU, 1, 2, 0, 0, s, fa, fb);
        issue(ALU, 0, 0, 9, 0, s, fa, fb);
        chk("R8 alu r0 fwd_a", fa, 0);
        chk("R8 alu r0 fwd_b", fb, 0);
        idle(8);
        issue(LD, 2, 0, 0, 0, s, fa, fb);
        issue(ALU, 0, 0, 9, 0, s, fa, fb);
        chk("R8 load r0 stalls", s, 0);
        idle(8);
    endtask

    task automatic t_priority();
        int s, fa, fb;
        issue(ALU, 1, 2, 5, 0, s, fa, fb);
        issue(ALU, 1, 3, 5, 0, s, fa, fb);
        issue(ALU, 5, 4, 9, 0, s, fa, fb);
        chk("R9 youngest wins", fa, 1);
        idle(8);
        issue(ALU, 1, 2, 6, 0, s, fa, fb);
        issue(ALU, 1, 2, 20, 0, s, fa, fb);
        issue(ALU, 3, 6, 21, 0, s, fa, fb);
        chk("R9 two ahead select", fb, 2);
        idle(8);
        issue(ALU, 1, 2, 6, 0, s, fa, fb);
        issue(ALU, 1, 2, 20, 0, s, fa, fb);
        issue(ALU, 1, 2, 21, 0, s, fa, fb);
        issue(ALU, 6, 2, 22, 0, s, fa, fb);
        chk("R9 three ahead select", fa, 0);
        chk("R9 three ahead stalls", s, 0);
        idle(8);
    endtask

    initial begin
        #(8 * 20000);
        fails++;
        total++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        #1;
        t_reset();
        t_alu_store();
        t_load_use();
        t_fp_chain();
        t_fp_store();
        t_mem_share();
        t_namespace();
        t_reg_zero();
        t_priority();
        chk("R11 idle no stall", stall, 0);
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

endmodule